// File: doc/BRIEF.md
# Guarded UART Configuration Bridge

This block connects a host that addresses UART registers by the classic byte index (0 to 15) to a UART core whose registers sit one per 32-bit word. Reads are translated to word addresses and passed through. Writes to the transmit holding, interrupt enable, scratch and divisor registers go straight through as single writes. A host write to the FIFO control, line control or modem control register is never sent on its own. It starts a hardware sequence instead. The sequence snapshots the live settings, flushes both FIFOs, pulses the core's soft reset and then writes every setting back, with the host's new value taking the place of the targeted register.

The host side is a valid/ready request channel: a request is taken on a clock edge where `h_valid` and `h_ready` are both high. The host must hold `h_valid`, `h_write`, `h_index` and `h_wdata` steady until that edge. `h_ready` drops for the whole sequence, so the bridge stalls requests during that time and drops none. Read data returns on `h_rvalid` with no back-pressure. The downstream side is a plain synchronous register port that takes one access per clock and returns read data on the cycle after the read strobe. The divisor latches can only be reached while line control bit 7 is set. Any change to the divisor is therefore covered by the reset that the line-control write setting that bit triggers.

Top module: `uart_guarded_cfg`

## Requirements
- R1: After reset `busy` and `h_rvalid` are low, `h_ready` is high and no downstream access is issued.
- R2: An accepted host read of index 0,1,2,3,4,5,6,7,9,10,11 issues a downstream read in the same cycle at byte address 0x00,0x04,0x08,0x10,0x14,0x18,0x1c,0x20,0x24,0x28,0x2c respectively. `h_rvalid` is high on the next cycle, with `h_rdata` equal to the word that was read.
- R3: An accepted host read of index 8, 12, 13, 14 or 15 issues no downstream access. It returns `h_rvalid` high with `h_rdata` = 0 on the next cycle.
- R4: An accepted host write to index 0, 1, 7, 9 or 10 issues one downstream write in the same cycle, at 0x00, 0x04, 0x20, 0x24 or 0x28, carrying `h_wdata`. `busy` stays low.
- R5: An accepted host write to index 5, 6, 8 or 11 to 15 is discarded. No downstream access is issued and no register changes.
- R6: An accepted host write to index 2 (FCR), 3 (LCR) or 4 (MCR) raises `busy` on the next cycle for exactly 13 cycles. `h_ready` is low whenever `busy` is high.
- R7: The sequence's first five cycles read 0x04, 0x10, 0x14, 0x2c and then 0x0c, one per cycle. The FIFO control word is read at 0x0c, not at the index-2 read address 0x08.
- R8: Next the sequence writes 0x0c with the saved FIFO control value ORed with 0x06 (bit 1 clears the receive FIFO, bit 2 clears the transmit FIFO). It then writes 0x2c with saved HCR0 | 0x80 (bit 7 is soft reset), and then 0x2c with saved HCR0 & ~0x80.
- R9: The last five cycles write 0x04, 0x0c, 0x14, 0x10 and 0x2c in that order, using the saved values. The targeted register gets the host's new value instead, and 0x2c gets its original saved value.
- R10: A host request presented while `busy` is high is held off, not lost. It is taken on the first cycle after `busy` falls and then takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Bridge can take a request this cycle |
| h_write | input | 1 | 1 = write, 0 = read |
| h_index | input | IDX_W | Byte-style register index |
| h_wdata | input | DATA_W | Host write data |
| h_rvalid | output | 1 | Read data valid (one cycle) |
| h_rdata | output | DATA_W | Read data |
| busy | output | 1 | Guarded update sequence in progress |
| d_en | output | 1 | Downstream access strobe |
| d_we | output | 1 | Downstream write enable |
| d_addr | output | ADDR_W | Downstream byte address (word aligned) |
| d_wdata | output | DATA_W | Downstream write data |
| d_rdata | input | DATA_W | Downstream read data, valid the cycle after a read strobe |

## Verification
Direct writes and read strobes appear on the downstream port in the same cycle as the request is taken, so the bench checks them on the falling edge before that acceptance edge. Read responses appear one clock later and are checked on the next falling edge. A guarded write produces its first downstream access one cycle after acceptance and its last 13 cycles after acceptance. The bench logs every strobe on falling edges and waits 15 cycles before comparing the whole trace, and the busy-cycle count, with a sequence it derives from the register model's contents before the write. A request stalled during the sequence is checked through the trace entry that follows the last restore.

// File: rtl/ugc_pkg.sv
package ugc_pkg;

  // downstream word slots (byte address = slot * 4)
  localparam int SLOT_DATA = 0;
  localparam int SLOT_IEN  = 1;
  localparam int SLOT_ISTS = 2;
  localparam int SLOT_FCTL = 3;
  localparam int SLOT_LCTL = 4;
  localparam int SLOT_MCTL = 5;
  localparam int SLOT_LSTS = 6;
  localparam int SLOT_MSTS = 7;
  localparam int SLOT_SCRT = 8;
  localparam int SLOT_DIVL = 9;
  localparam int SLOT_DIVH = 10;
  localparam int SLOT_HCTL = 11;

  // control bit positions the UART core decodes
  localparam int RXCLR_BIT = 1;
  localparam int TXCLR_BIT = 2;
  localparam int SRST_BIT  = 7;

  typedef enum logic [1:0] {
    WK_DROP   = 2'd0,
    WK_DIRECT = 2'd1,
    WK_GUARD  = 2'd2
  } wr_kind_e;

  typedef enum logic [1:0] {
    TG_FCTL = 2'd0,
    TG_LCTL = 2'd1,
    TG_MCTL = 2'd2
  } guard_tgt_e;

  // states in execution order; each lasts one clock
  typedef enum logic [3:0] {
    ST_IDLE     = 4'd0,
    ST_RD_IEN   = 4'd1,
    ST_RD_LCTL  = 4'd2,
    ST_RD_MCTL  = 4'd3,
    ST_RD_HCTL  = 4'd4,
    ST_RD_FCTL  = 4'd5,
    ST_FLUSH    = 4'd6,
    ST_RST_ON   = 4'd7,
    ST_RST_OFF  = 4'd8,
    ST_PUT_IEN  = 4'd9,
    ST_PUT_FCTL = 4'd10,
    ST_PUT_MCTL = 4'd11,
    ST_PUT_LCTL = 4'd12,
    ST_PUT_HCTL = 4'd13
  } seq_state_e;

endpackage

// File: rtl/ugc_index_map.sv
module ugc_index_map
  import ugc_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int WORD_W = 4
) (
  input  logic [IDX_W-1:0]  index,
  output logic [WORD_W-1:0] rd_slot,
  output logic              rd_ok,
  output logic [WORD_W-1:0] wr_slot,
  output wr_kind_e          wr_kind,
  output guard_tgt_e        tgt
);

  always_comb begin
    rd_ok   = 1'b1;
    rd_slot = '0;
    unique case (index)
      IDX_W'(0):  rd_slot = WORD_W'(SLOT_DATA);
      IDX_W'(1):  rd_slot = WORD_W'(SLOT_IEN);
      IDX_W'(2):  rd_slot = WORD_W'(SLOT_ISTS);
      IDX_W'(3):  rd_slot = WORD_W'(SLOT_LCTL);
      IDX_W'(4):  rd_slot = WORD_W'(SLOT_MCTL);
      IDX_W'(5):  rd_slot = WORD_W'(SLOT_LSTS);
      IDX_W'(6):  rd_slot = WORD_W'(SLOT_MSTS);
      IDX_W'(7):  rd_slot = WORD_W'(SLOT_SCRT);
      IDX_W'(9):  rd_slot = WORD_W'(SLOT_DIVL);
      IDX_W'(10): rd_slot = WORD_W'(SLOT_DIVH);
      IDX_W'(11): rd_slot = WORD_W'(SLOT_HCTL);
      default:    rd_ok   = 1'b0;
    endcase
  end

  always_comb begin
    wr_kind = WK_DROP;
    wr_slot = '0;
    tgt     = TG_FCTL;
    unique case (index)
      IDX_W'(0):  begin wr_kind = WK_DIRECT; wr_slot = WORD_W'(SLOT_DATA); end
      IDX_W'(1):  begin wr_kind = WK_DIRECT; wr_slot = WORD_W'(SLOT_IEN);  end
      IDX_W'(7):  begin wr_kind = WK_DIRECT; wr_slot = WORD_W'(SLOT_SCRT); end
      IDX_W'(9):  begin wr_kind = WK_DIRECT; wr_slot = WORD_W'(SLOT_DIVL); end
      IDX_W'(10): begin wr_kind = WK_DIRECT; wr_slot = WORD_W'(SLOT_DIVH); end
      IDX_W'(2):  begin wr_kind = WK_GUARD;  tgt = TG_FCTL; end
      IDX_W'(3):  begin wr_kind = WK_GUARD;  tgt = TG_LCTL; end
      IDX_W'(4):  begin wr_kind = WK_GUARD;  tgt = TG_MCTL; end
      default:    wr_kind = WK_DROP;
    endcase
  end

endmodule

// File: rtl/ugc_guard_seq.sv
module ugc_guard_seq
  import ugc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  guard_tgt_e        start_tgt,
  input  logic [DATA_W-1:0] start_val,
  input  logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic              en,
  output logic              we,
  output logic [WORD_W-1:0] slot,
  output logic [DATA_W-1:0] wdata
);

  localparam logic [DATA_W-1:0] FLUSH_MASK =
    (DATA_W'(1) << RXCLR_BIT) | (DATA_W'(1) << TXCLR_BIT);
  localparam logic [DATA_W-1:0] SRST_MASK = DATA_W'(1) << SRST_BIT;

  seq_state_e        state_q;
  guard_tgt_e        tgt_q;
  logic [DATA_W-1:0] new_q;
  logic [DATA_W-1:0] sv_ien, sv_lctl, sv_mctl, sv_hctl, sv_fctl;
  logic [DATA_W-1:0] put_fctl, put_lctl, put_mctl;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else if (state_q == ST_IDLE) begin
      if (start) state_q <= ST_RD_IEN;
    end else if (state_q == ST_PUT_HCTL) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= seq_state_e'(4'(state_q) + 4'd1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q <= TG_FCTL;
      new_q <= '0;
    end else if (state_q == ST_IDLE && start) begin
      tgt_q <= start_tgt;
      new_q <= start_val;
    end
  end

  // each read lands one cycle after its strobe, so capture is one state late
  always_ff @(posedge clk) begin
    if (rst) begin
      sv_ien  <= '0;
      sv_lctl <= '0;
      sv_mctl <= '0;
      sv_hctl <= '0;
      sv_fctl <= '0;
    end else begin
      unique case (state_q)
        ST_RD_LCTL: sv_ien  <= rdata;
        ST_RD_MCTL: sv_lctl <= rdata;
        ST_RD_HCTL: sv_mctl <= rdata;
        ST_RD_FCTL: sv_hctl <= rdata;
        ST_FLUSH:   sv_fctl <= rdata;
        default: ;
      endcase
    end
  end

  assign put_fctl = (tgt_q == TG_FCTL) ? new_q : sv_fctl;
  assign put_lctl = (tgt_q == TG_LCTL) ? new_q : sv_lctl;
  assign put_mctl = (tgt_q == TG_MCTL) ? new_q : sv_mctl;

  always_comb begin
    en    = 1'b1;
    we    = 1'b1;
    slot  = '0;
    wdata = '0;
    unique case (state_q)
      ST_IDLE:     en = 1'b0;
      ST_RD_IEN:   begin we = 1'b0; slot = WORD_W'(SLOT_IEN);  end
      ST_RD_LCTL:  begin we = 1'b0; slot = WORD_W'(SLOT_LCTL); end
      ST_RD_MCTL:  begin we = 1'b0; slot = WORD_W'(SLOT_MCTL); end
      ST_RD_HCTL:  begin we = 1'b0; slot = WORD_W'(SLOT_HCTL); end
      ST_RD_FCTL:  begin we = 1'b0; slot = WORD_W'(SLOT_FCTL); end
      ST_FLUSH:    begin slot = WORD_W'(SLOT_FCTL); wdata = rdata | FLUSH_MASK; end
      ST_RST_ON:   begin slot = WORD_W'(SLOT_HCTL); wdata = sv_hctl | SRST_MASK; end
      ST_RST_OFF:  begin slot = WORD_W'(SLOT_HCTL); wdata = sv_hctl & ~SRST_MASK; end
      ST_PUT_IEN:  begin slot = WORD_W'(SLOT_IEN);  wdata = sv_ien;   end
      ST_PUT_FCTL: begin slot = WORD_W'(SLOT_FCTL); wdata = put_fctl; end
      ST_PUT_MCTL: begin slot = WORD_W'(SLOT_MCTL); wdata = put_mctl; end
      ST_PUT_LCTL: begin slot = WORD_W'(SLOT_LCTL); wdata = put_lctl; end
      ST_PUT_HCTL: begin slot = WORD_W'(SLOT_HCTL); wdata = sv_hctl;  end
      default:     en = 1'b0;
    endcase
  end

  assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/ugc_read_resp.sv
module ugc_read_resp #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_take,
  input  logic              rd_ok,
  input  logic [DATA_W-1:0] d_rdata,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);

  logic zero_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      rvalid <= rd_take;
      zero_q <= rd_take & ~rd_ok;
    end
  end

  assign rdata = (rvalid && !zero_q) ? d_rdata : '0;

endmodule

// File: rtl/uart_guarded_cfg.sv
module uart_guarded_cfg
  import ugc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_valid,
  output logic              h_ready,
  input  logic              h_write,
  input  logic [IDX_W-1:0]  h_index,
  input  logic [DATA_W-1:0] h_wdata,
  output logic              h_rvalid,
  output logic [DATA_W-1:0] h_rdata,
  output logic              busy,
  output logic              d_en,
  output logic              d_we,
  output logic [ADDR_W-1:0] d_addr,
  output logic [DATA_W-1:0] d_wdata,
  input  logic [DATA_W-1:0] d_rdata
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] rd_slot, wr_slot, seq_slot;
  logic              rd_ok;
  wr_kind_e          wr_kind;
  guard_tgt_e        tgt;
  logic              take, take_rd, take_direct, take_guard;
  logic              seq_en, seq_we;
  logic [DATA_W-1:0] seq_wdata;

  ugc_index_map #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_map (
    .index   (h_index),
    .rd_slot (rd_slot),
    .rd_ok   (rd_ok),
    .wr_slot (wr_slot),
    .wr_kind (wr_kind),
    .tgt     (tgt)
  );

  assign h_ready     = ~busy;
  assign take        = h_valid & h_ready;
  assign take_rd     = take & ~h_write;
  assign take_direct = take & h_write & (wr_kind == WK_DIRECT);
  assign take_guard  = take & h_write & (wr_kind == WK_GUARD);

  ugc_guard_seq #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (take_guard),
    .start_tgt (tgt),
    .start_val (h_wdata),
    .rdata     (d_rdata),
    .busy      (busy),
    .en        (seq_en),
    .we        (seq_we),
    .slot      (seq_slot),
    .wdata     (seq_wdata)
  );

  ugc_read_resp #(.DATA_W(DATA_W)) u_rsp (
    .clk     (clk),
    .rst     (rst),
    .rd_take (take_rd),
    .rd_ok   (rd_ok),
    .d_rdata (d_rdata),
    .rvalid  (h_rvalid),
    .rdata   (h_rdata)
  );

  always_comb begin
    if (busy) begin
      d_en    = seq_en;
      d_we    = seq_we;
      d_addr  = {seq_slot, 2'b00};
      d_wdata = seq_wdata;
    end else begin
      d_en    = take_direct | (take_rd & rd_ok);
      d_we    = h_write;
      d_addr  = h_write ? {wr_slot, 2'b00} : {rd_slot, 2'b00};
      d_wdata = h_wdata;
    end
  end

endmodule

// File: rtl/ugc_checker.sv
module ugc_checker #(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              h_valid,
  input logic              h_ready,
  input logic              h_write,
  input logic [IDX_W-1:0]  h_index,
  input logic              h_rvalid,
  input logic              busy,
  input logic              d_en,
  input logic              d_we,
  input logic [ADDR_W-1:0] d_addr
);

  logic is_direct, is_guard, is_drop;
  assign is_direct = (h_index == IDX_W'(0)) || (h_index == IDX_W'(1)) ||
                     (h_index == IDX_W'(7)) || (h_index == IDX_W'(9)) ||
                     (h_index == IDX_W'(10));
  assign is_guard  = (h_index == IDX_W'(2)) || (h_index == IDX_W'(3)) ||
                     (h_index == IDX_W'(4));
  assign is_drop   = !is_direct && !is_guard;

  a_r6_ready_low_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !h_ready);

  a_r6_guard_raises_busy: assert property (@(posedge clk) disable iff (rst)
    (h_valid && h_ready && h_write && is_guard) |=> busy);

  a_r4_direct_no_busy: assert property (@(posedge clk) disable iff (rst)
    (h_valid && h_ready && h_write && is_direct) |-> (d_en && d_we) ##1 !busy);

  a_r5_drop_no_access: assert property (@(posedge clk) disable iff (rst)
    (h_valid && h_ready && h_write && is_drop) |-> !d_en);

  a_r2_read_response: assert property (@(posedge clk) disable iff (rst)
    (h_valid && h_ready && !h_write) |=> h_rvalid);

  a_r7_first_access: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (d_en && !d_we && d_addr == ADDR_W'(6'h04)));

  a_r9_last_restore: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(d_en && d_we && d_addr == ADDR_W'(6'h2c)));

endmodule

bind uart_guarded_cfg ugc_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .h_valid  (h_valid),
  .h_ready  (h_ready),
  .h_write  (h_write),
  .h_index  (h_index),
  .h_rvalid (h_rvalid),
  .busy     (busy),
  .d_en     (d_en),
  .d_we     (d_we),
  .d_addr   (d_addr)
);

// File: tb/test_uart_guarded_cfg.sv
module test_uart_guarded_cfg;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       h_valid = 1'b0, h_write = 1'b0;
  logic [3:0] h_index = '0;
  logic [7:0] h_wdata = '0;
  logic       h_ready, h_rvalid, busy, d_en, d_we;
  logic [7:0] h_rdata, d_wdata;
  logic [5:0] d_addr;
  logic [7:0] d_rdata = '0;

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_guarded_cfg i_uart_guarded_cfg (
    .clk(clk), .rst(rst), .h_valid(h_valid), .h_ready(h_ready),
    .h_write(h_write), .h_index(h_index), .h_wdata(h_wdata),
    .h_rvalid(h_rvalid), .h_rdata(h_rdata), .busy(busy),
    .d_en(d_en), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata),
    .d_rdata(d_rdata)
  );

  // downstream register model, one byte per word slot
  logic [7:0] mem [16];
  always @(posedge clk) begin
    if (d_en && !d_we) d_rdata <= mem[d_addr[5:2]];
    if (d_en && d_we)  mem[d_addr[5:2]] <= d_wdata;
  end

  // trace of downstream strobes and busy/ready behaviour
  logic       lg_we   [32];
  logic [5:0] lg_addr [32];
  logic [7:0] lg_data [32];
  int n_log = 0, busy_cnt = 0, rdy_err = 0;
  always @(negedge clk) begin
    if (!rst && d_en && n_log < 32) begin
      lg_we[n_log]   <= d_we;
      lg_addr[n_log] <= d_addr;
      lg_data[n_log] <= d_wdata;
      n_log <= n_log + 1;
    end
    if (busy) busy_cnt <= busy_cnt + 1;
    if (busy && h_ready) rdy_err <= rdy_err + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] rd_addr_of(input int idx);
    case (idx)
      0: return 6'h00;  1: return 6'h04;  2: return 6'h08;  3: return 6'h10;
      4: return 6'h14;  5: return 6'h18;  6: return 6'h1c;  7: return 6'h20;
      9: return 6'h24; 10: return 6'h28; 11: return 6'h2c;
      default: return 6'h3f;
    endcase
  endfunction

  task automatic clear_log();
    @(negedge clk);
    n_log = 0; busy_cnt = 0; rdy_err = 0;
  endtask

  // hold the request until taken, then release on the next falling edge
  task automatic host_write(input int idx, input logic [7:0] val);
    h_valid = 1'b1; h_write = 1'b1; h_index = 4'(idx); h_wdata = val;
    #1;
    while (!h_ready) @(negedge clk);
    @(negedge clk);
    h_valid = 1'b0; h_write = 1'b0;
  endtask

  task automatic test_reset();
    check("R1 busy", busy, 0);
    check("R1 ready", h_ready, 1);
    check("R1 rvalid", h_rvalid, 0);
    check("R1 d_en", d_en, 0);
  endtask

  task automatic test_reads();
    for (int i = 0; i < 16; i++) begin
      logic [7:0] exp;
      logic ok;
      ok = (rd_addr_of(i) != 6'h3f);
      h_valid = 1'b1; h_write = 1'b0; h_index = 4'(i);
      #1;
      if (ok) begin
        check("R2 read strobe", {d_en, d_we}, 2'b10);
        check("R2 read addr", d_addr, rd_addr_of(i));
        exp = mem[rd_addr_of(i)[5:2]];
      end else begin
        check("R3 no access", d_en, 0);
        exp = 8'h00;
      end
      @(negedge clk);
      h_valid = 1'b0;
      check(ok ? "R2 rvalid" : "R3 rvalid", h_rvalid, 1);
      check(ok ? "R2 rdata" : "R3 rdata zero", h_rdata, exp);
    end
  endtask

  task automatic test_direct();
    int idx [5] = '{0, 1, 7, 9, 10};
    logic [5:0] ad [5] = '{6'h00, 6'h04, 6'h20, 6'h24, 6'h28};
    for (int k = 0; k < 5; k++) begin
      logic [7:0] v;
      v = 8'h90 + 8'(k);
      h_valid = 1'b1; h_write = 1'b1; h_index = 4'(idx[k]); h_wdata = v;
      #1;
      check("R4 write strobe", {d_en, d_we}, 2'b11);
      check("R4 write addr", d_addr, ad[k]);
      check("R4 write data", d_wdata, v);
      @(negedge clk);
      h_valid = 1'b0; h_write = 1'b0;
      check("R4 no busy", busy, 0);
      check("R4 stored", mem[ad[k][5:2]], v);
    end
  endtask

  task automatic test_dropped();
    int idx [9] = '{5, 6, 8, 11, 12, 13, 14, 15, 11};
    logic [7:0] snap [16];
    for (int s = 0; s < 16; s++) snap[s] = mem[s];
    for (int k = 0; k < 9; k++) begin
      h_valid = 1'b1; h_write = 1'b1; h_index = 4'(idx[k]); h_wdata = 8'hEE;
      #1;
      check("R5 no access", d_en, 0);
      @(negedge clk);
      h_valid = 1'b0; h_write = 1'b0;
      check("R5 no busy", busy, 0);
    end
    // bring HCR0 out through a normal host read
    h_valid = 1'b1; h_index = 4'd11;
    @(negedge clk);
    h_valid = 1'b0;
    check("R5 hcr0 unchanged", h_rdata, snap[11]);
    for (int s = 0; s < 16; s++) check("R5 reg unchanged", mem[s], snap[s]);
  endtask

  task automatic test_guarded(input int idx, input logic [7:0] val);
    logic [7:0] ien, fctl, lctl, mctl, hctl;
    logic       ew [13];
    logic [5:0] ea [13];
    logic [7:0] ed [13];
    ien = mem[1]; fctl = mem[3]; lctl = mem[4]; mctl = mem[5]; hctl = mem[11];
    ew = '{0,0,0,0,0,1,1,1,1,1,1,1,1};
    ea = '{6'h04,6'h10,6'h14,6'h2c,6'h0c,6'h0c,6'h2c,6'h2c,6'h04,6'h0c,6'h14,6'h10,6'h2c};
    ed = '{0,0,0,0,0, fctl | 8'h06, hctl | 8'h80, hctl & 8'h7f, ien,
           (idx == 2) ? val : fctl, (idx == 4) ? val : mctl,
           (idx == 3) ? val : lctl, hctl};
    clear_log();
    host_write(idx, val);
    repeat (15) @(negedge clk);
    check("R6 busy cycles", busy_cnt, 13);
    check("R6 ready low while busy", rdy_err, 0);
    check("R7 trace length", n_log, 13);
    for (int k = 0; k < 13; k++) begin
      check(k < 5 ? "R7 save op" : (k < 8 ? "R8 flush op" : "R9 restore op"), lg_we[k], ew[k]);
      check(k < 5 ? "R7 save addr" : (k < 8 ? "R8 flush addr" : "R9 restore addr"), lg_addr[k], ea[k]);
      if (ew[k]) check(k < 8 ? "R8 flush data" : "R9 restore data", lg_data[k], ed[k]);
    end
  endtask

  task automatic test_stall();
    clear_log();
    host_write(4, 8'h1B);
    host_write(1, 8'h3C);   // presented while busy
    repeat (3) @(negedge clk);
    check("R10 trace length", n_log, 14);
    check("R10 late write addr", lg_addr[13], 6'h04);
    check("R10 late write data", lg_data[13], 8'h3C);
    check("R10 ien final", mem[1], 8'h3C);
    check("R10 mctl final", mem[5], 8'h1B);
  endtask

  initial begin
    mem = '{8'h11, 8'h05, 8'hC1, 8'h41, 8'h03, 8'h08, 8'h60, 8'hB0,
            8'h5A, 8'h1A, 8'h00, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00};
    repeat (3) @(negedge clk);
    test_reset();
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_reads();
    test_direct();
    test_dropped();
    test_guarded(3, 8'h83);
    test_guarded(2, 8'hC7);
    test_guarded(4, 8'h0B);
    test_guarded(3, 8'h03);
    test_stall();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=finish", LIMIT);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule